// File: doc/BRIEF.md
# Serial Character Receiver with Parallel Register Port

This block takes an asynchronous serial line and turns it into bytes that a host reads over a small parallel bus. It synchronises the line, oversamples each bit, finds and checks the start bit, and collects 5 to 8 data bits. An optional parity bit is checked, in normal or fixed ("stick") form, and then one or two stop bits. Every finished character lands in a receive holding register. A data-ready flag is raised, and a level interrupt follows it when enabled.

The host sees four registers: the receive holding register, an interrupt enable register, a line setup register and a line status register. A bus cycle first latches an address with an active-low address strobe. Then an active-low read or write strobe qualifies the access while chip select is high. The baud rate is fixed by the `CLKS_PER_TICK` parameter, the number of clock cycles per oversampling tick. There is no transmitter, so both transmitter-empty status flags always read 1. The data-ready flag and the interrupt clear only when the holding register is read.

Top module: `sio_receiver`

## Requirements
- R1: The line setup register bits [1:0] select the character length: 00=5, 01=6, 10=7, 11=8 data bits, sent LSB first. A shorter character is returned right-justified in the holding register, with the unused upper bits at 0.
- R2: Setup bit 3 enables a parity bit, which directly follows the last data bit. Setup bit 4 set asks for even parity, and clear asks for odd. A received parity bit that disagrees sets status bit 2.
- R3: When setup bit 5 (stick) is set with parity enabled, the expected parity bit is the constant 0 if bit 4 is 1 and the constant 1 if bit 4 is 0, whatever the data.
- R4: Setup bit 2 clear means one stop bit and set means two. If any stop bit is sampled low, status bit 4 (framing error) is set. After a low final stop bit, the receiver waits for the line to go high before it hunts for the next start.
- R5: A falling line starts a character only if the line is still low at the middle of the start bit. A shorter low pulse produces no character and leaves the receiver ready for the next one.
- R6: The status register is {0,1,1,framing,0,parity,overrun,ready}. It reads 8'h60 when idle and 8'h61 after a clean character.
- R7: Reading the status register leaves the ready flag and the interrupt unchanged. It clears status bits 1, 2 and 4, so the following read shows only the ready flag and the constant bits.
- R8: Reading the holding register returns the character and clears the ready flag, and the interrupt falls by the clock after the read.
- R9: The interrupt output equals enable register bit 0 AND the ready flag. With bit 0 clear it stays low while characters arrive.
- R10: A character that completes while the ready flag is still set sets status bit 1 (overrun), and the holding register takes the newer character.
- R11: Register offsets are holding 0 (read), enable 1 (bits 3:0 stored, 7:4 read 0), setup 3 (8 bits, read/write) and status 5 (read only). Unlisted offsets read 0, and writes to offsets 0 and 5 have no effect. Reset values are setup 8'h03 and enable 8'h00.
- R12: The address is captured on a clock edge where chip select is high and the address strobe is low. A write takes effect on each clock edge with chip select high and the write strobe low. A read is captured on the first clock edge with chip select high and the read strobe low, and that value stays on the read data output until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Chip select, active high |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, held between reads |
| ser_in | input | 1 | Asynchronous serial line, idle high |
| irq | output | 1 | Level interrupt for received data |

## Verification
The bench sweeps every byte value at eight bits, then every character length against every parity mode, with both correct and deliberately wrong parity bits. A receiver that took stick parity as plain parity, or left stale upper bits in short characters, would report parity errors or wrong data there. Directed cases cover a low final stop bit, where a design that re-armed at once would invent a phantom character. They also cover a sub-half-bit glitch, which must not start a frame, and a second character arriving unread, which must flag overrun while keeping the newer data. Status reads are repeated to catch a design that clears ready or drops the interrupt on a status read instead of only on a holding-register read.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

  localparam int BUS_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_HOLD   = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_SETUP  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 3'd5;

  typedef enum logic [2:0] {
    FR_IDLE, FR_START, FR_DATA, FR_PAR, FR_STOP, FR_HOLD
  } fr_state_e;

  typedef struct packed {
    logic [1:0] len_sel;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } frame_cfg_t;

  typedef struct packed {
    logic [BUS_W-1:0] data;
    logic             par_err;
    logic             frm_err;
  } rx_word_t;

  // number of data bits for a length code
  function automatic logic [3:0] data_bits(logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction

  // mask of the valid data bits for a length code
  function automatic logic [BUS_W-1:0] len_mask(logic [1:0] sel);
    return 8'hFF >> (3'd3 - {1'b0, sel});
  endfunction

  // parity bit the line must carry for this data and setup
  function automatic logic exp_parity(logic [BUS_W-1:0] data, frame_cfg_t cfg);
    logic ones;
    ones = ^(data & len_mask(cfg.len_sel));
    if (cfg.par_stick) return ~cfg.par_even;
    return cfg.par_even ? ones : ~ones;
  endfunction

endpackage

// File: rtl/sio_rx_sampler.sv
module sio_rx_sampler #(
  parameter int CLKS_PER_TICK = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  output logic rx_s,
  output logic tick
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], ser_in};
  end

  assign rx_s = sync_q[1];

  generate
    if (CLKS_PER_TICK <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(CLKS_PER_TICK);
      localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + CW'(1);
      end

      assign tick = (cnt_q == LAST);

      // R5: ticks are spaced so the mid-bit sample point is well defined
      a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/sio_rx_framer.sv
module sio_rx_framer
  import sio_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_s,
  input  frame_cfg_t cfg,
  output logic       done,
  output rx_word_t   word
);

  localparam int PH_W = $clog2(OVERSAMPLE);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVERSAMPLE / 2 - 1);

  fr_state_e        st_q;
  logic [PH_W-1:0]  ph_q;
  logic [2:0]       idx_q;
  logic [BUS_W-1:0] sh_q;
  logic             stop_cnt_q;
  logic             frm_q;
  logic             par_bit_q;
  logic             done_q;
  rx_word_t         word_q;

  // named events
  logic       bit_mid;
  logic       start_check;
  logic       start_confirm;
  logic       start_reject;
  logic       last_data;
  logic       stop_last;
  logic [3:0] nb_m1;

  assign bit_mid       = tick && (ph_q == PH_LAST);
  assign start_check   = (st_q == FR_START) && tick && (ph_q == PH_MID);
  assign start_confirm = start_check && !rx_s;
  assign start_reject  = start_check && rx_s;
  assign nb_m1         = data_bits(cfg.len_sel) - 4'd1;
  assign last_data     = (idx_q == nb_m1[2:0]);
  assign stop_last     = (stop_cnt_q == cfg.two_stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= FR_IDLE;
      ph_q       <= '0;
      idx_q      <= '0;
      sh_q       <= '0;
      stop_cnt_q <= 1'b0;
      frm_q      <= 1'b0;
      par_bit_q  <= 1'b0;
      done_q     <= 1'b0;
      word_q     <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        FR_IDLE: begin
          if (tick && !rx_s) begin
            st_q <= FR_START;
            ph_q <= '0;
          end
        end
        FR_START: begin
          if (start_reject) begin
            st_q <= FR_IDLE;
          end else if (start_confirm) begin
            st_q  <= FR_DATA;
            ph_q  <= '0;
            idx_q <= '0;
            sh_q  <= '0;
            frm_q <= 1'b0;
          end else if (tick) begin
            ph_q <= ph_q + PH_W'(1);
          end
        end
        FR_DATA: begin
          if (bit_mid) begin
            sh_q[idx_q] <= rx_s;
            ph_q        <= '0;
            if (last_data) begin
              st_q       <= cfg.par_en ? FR_PAR : FR_STOP;
              stop_cnt_q <= 1'b0;
            end else begin
              idx_q <= idx_q + 3'd1;
            end
          end else if (tick) begin
            ph_q <= ph_q + PH_W'(1);
          end
        end
        FR_PAR: begin
          if (bit_mid) begin
            par_bit_q  <= rx_s;
            ph_q       <= '0;
            stop_cnt_q <= 1'b0;
            st_q       <= FR_STOP;
          end else if (tick) begin
            ph_q <= ph_q + PH_W'(1);
          end
        end
        FR_STOP: begin
          if (bit_mid) begin
            ph_q <= '0;
            if (stop_last) begin
              done_q         <= 1'b1;
              word_q.data    <= sh_q;
              word_q.par_err <= cfg.par_en && (par_bit_q != exp_parity(sh_q, cfg));
              word_q.frm_err <= frm_q || !rx_s;
              st_q           <= rx_s ? FR_IDLE : FR_HOLD;
            end else begin
              stop_cnt_q <= 1'b1;
              frm_q      <= frm_q || !rx_s;
            end
          end else if (tick) begin
            ph_q <= ph_q + PH_W'(1);
          end
        end
        FR_HOLD: begin
          if (rx_s) st_q <= FR_IDLE;
        end
        default: st_q <= FR_IDLE;
      endcase
    end
  end

  assign done = done_q;
  assign word = word_q;

  // R5: a start that is high again at mid-bit never yields data collection
  a_r5_glitch_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> (st_q == FR_IDLE) && !done);

  // R4: a low final stop bit is reported as a framing error
  a_r4_low_stop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_STOP) && bit_mid && stop_last && !rx_s |=> done && word.frm_err);

  // R4: after a low final stop the receiver stays parked until the line rises
  a_r4_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_HOLD) && !rx_s |=> (st_q == FR_HOLD));

  // R1: a 7-bit character never carries a set bit 7
  a_r1_short_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_STOP) && bit_mid && stop_last && (cfg.len_sel == 2'b10)
      |=> !word.data[7]);

endmodule

// File: rtl/sio_rx_regs.sv
module sio_rx_regs
  import sio_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_as_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              char_done,
  input  rx_word_t          char_in,
  output frame_cfg_t        cfg,
  output logic              irq
);

  logic [ADDR_W-1:0] addr_q;
  logic              rd_n_q;
  logic [3:0]        ier_q;
  logic [BUS_W-1:0]  lcr_q;
  logic [BUS_W-1:0]  rbr_q;
  logic              dr_q, ovr_q, pe_q, fe_q;
  logic [BUS_W-1:0]  rdata_q;
  logic [BUS_W-1:0]  status_val;
  logic [BUS_W-1:0]  rd_mux;

  // named bus events
  logic rd_evt, wr_evt, rd_hold, rd_status, wr_enable, wr_setup;

  assign rd_evt    = bus_cs && !bus_rd_n && rd_n_q;
  assign wr_evt    = bus_cs && !bus_wr_n;
  assign rd_hold   = rd_evt && (addr_q == OFS_HOLD);
  assign rd_status = rd_evt && (addr_q == OFS_STATUS);
  assign wr_enable = wr_evt && (addr_q == OFS_ENABLE);
  assign wr_setup  = wr_evt && (addr_q == OFS_SETUP);

  assign status_val = {1'b0, 1'b1, 1'b1, fe_q, 1'b0, pe_q, ovr_q, dr_q};

  always_comb begin
    case (addr_q)
      OFS_HOLD:   rd_mux = rbr_q;
      OFS_ENABLE: rd_mux = {4'h0, ier_q};
      OFS_SETUP:  rd_mux = lcr_q;
      OFS_STATUS: rd_mux = status_val;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rd_n_q  <= 1'b1;
      ier_q   <= 4'h0;
      lcr_q   <= 8'h03;
      rbr_q   <= '0;
      dr_q    <= 1'b0;
      ovr_q   <= 1'b0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      rd_n_q <= bus_rd_n;
      if (bus_cs && !bus_as_n) addr_q <= bus_addr;
      if (wr_enable) ier_q <= bus_wdata[3:0];
      if (wr_setup)  lcr_q <= bus_wdata;
      if (rd_evt)    rdata_q <= rd_mux;
      if (char_done) rbr_q <= char_in.data;
      if (char_done)    dr_q <= 1'b1;
      else if (rd_hold) dr_q <= 1'b0;
      ovr_q <= (ovr_q && !rd_status) || (char_done && dr_q && !rd_hold);
      pe_q  <= (pe_q  && !rd_status) || (char_done && char_in.par_err);
      fe_q  <= (fe_q  && !rd_status) || (char_done && char_in.frm_err);
    end
  end

  assign cfg.len_sel   = lcr_q[1:0];
  assign cfg.two_stop  = lcr_q[2];
  assign cfg.par_en    = lcr_q[3];
  assign cfg.par_even  = lcr_q[4];
  assign cfg.par_stick = lcr_q[5];

  assign bus_rdata = rdata_q;
  assign irq       = ier_q[0] && dr_q;

  // R8: reading the holding register clears ready unless a new character lands
  a_r8_hold_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hold && !char_done |=> !dr_q && !irq);

  // R7: a status read keeps the ready flag and the interrupt
  a_r7_status_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && dr_q |=> dr_q && (irq == $past(irq)));

  // R7: a status read clears the sticky error bits
  a_r7_status_clears_errors: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && !char_done |=> !ovr_q && !pe_q && !fe_q);

  // R10: a character over an unread one flags overrun
  a_r10_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && dr_q && !rd_hold |=> ovr_q);

  // R12: read data only moves on a read event
  a_r12_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(bus_rdata));

endmodule

// File: rtl/sio_receiver.sv
module sio_receiver
  import sio_rx_pkg::*;
#(
  parameter int CLKS_PER_TICK = 4,
  parameter int OVERSAMPLE    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_as_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              ser_in,
  output logic              irq
);

  logic       rx_s;
  logic       tick;
  logic       char_done;
  rx_word_t   char_word;
  frame_cfg_t cfg;

  sio_rx_sampler #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_sampler (
    .clk    (clk),
    .rst_n  (rst_n),
    .ser_in (ser_in),
    .rx_s   (rx_s),
    .tick   (tick)
  );

  sio_rx_framer #(.OVERSAMPLE(OVERSAMPLE)) u_framer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .rx_s  (rx_s),
    .cfg   (cfg),
    .done  (char_done),
    .word  (char_word)
  );

  sio_rx_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cs    (bus_cs),
    .bus_as_n  (bus_as_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .char_done (char_done),
    .char_in   (char_word),
    .cfg       (cfg),
    .irq       (irq)
  );

endmodule

// File: tb/sio_receiver_bench.sv
module sio_receiver_bench;

  localparam int TPC  = 2;
  localparam int OVS  = 16;
  localparam int BIT  = TPC * OVS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_cs = 1'b0;
  logic       bus_as_n = 1'b1;
  logic       bus_rd_n = 1'b1;
  logic       bus_wr_n = 1'b1;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ser_in = 1'b1;
  logic       irq;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  sio_receiver #(.CLKS_PER_TICK(TPC), .OVERSAMPLE(OVS)) u_sio_receiver (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_as_n(bus_as_n),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_in(ser_in), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_cs = 1'b1; bus_as_n = 1'b0; bus_addr = a;
    @(negedge clk); bus_as_n = 1'b1; bus_wr_n = 1'b0; bus_wdata = d;
    @(negedge clk); bus_wr_n = 1'b1; bus_cs = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_cs = 1'b1; bus_as_n = 1'b0; bus_addr = a;
    @(negedge clk); bus_as_n = 1'b1; bus_rd_n = 1'b0;
    @(negedge clk); d = bus_rdata; bus_rd_n = 1'b1; bus_cs = 1'b0;
  endtask

  task automatic line_bit(input logic v);
    ser_in = v;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nbits, input bit pen,
                            input bit pbit, input bit two, input bit s0, input bit s1);
    @(negedge clk);
    line_bit(1'b0);
    for (int i = 0; i < nbits; i++) line_bit(d[i]);
    if (pen) line_bit(pbit);
    line_bit(s0);
    if (two) line_bit(s1);
    ser_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // expected parity bit, worked out from the setup bits
  function automatic bit want_par(input logic [7:0] d, input int nbits,
                                  input bit even, input bit stick);
    int ones = 0;
    for (int i = 0; i < nbits; i++) ones += int'(d[i]);
    if (stick) return !even;
    return even ? (ones % 2 == 1) : (ones % 2 == 0);
  endfunction

  // pmode: 0 none, 1 odd, 2 even, 3 stick with odd, 4 stick with even
  task automatic run_char(input logic [7:0] d, input logic [1:0] sel, input int pmode,
                          input bit bad, input string req);
    logic [7:0] lcr, got, exp_lsr;
    bit pen, even, stick, pb;
    int nbits;
    pen   = (pmode != 0);
    even  = (pmode == 2) || (pmode == 4);
    stick = (pmode >= 3);
    nbits = 5 + int'(sel);
    lcr   = {2'b00, stick, even, pen, 1'b0, sel};
    bus_write(3'd3, lcr);
    pb = want_par(d, nbits, even, stick) ^ bad;
    send_frame(d, nbits, pen, pb, 1'b0, 1'b1, 1'b1);
    exp_lsr = (pen && bad) ? 8'h65 : 8'h61;
    check("R9 irq after char", {7'd0, irq}, 8'h01);
    bus_read(3'd5, got); check({req, " R6 status"}, got, exp_lsr);
    bus_read(3'd5, got); check("R7 status reread", got, 8'h61);
    check("R7 irq kept", {7'd0, irq}, 8'h01);
    bus_read(3'd0, got);
    check({req, " data"}, got, d & 8'((1 << nbits) - 1));
    check("R8 irq cleared", {7'd0, irq}, 8'h00);
    bus_read(3'd5, got); check("R8 status after data read", got, 8'h60);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state, R11 / R6
    check("R9 irq at reset", {7'd0, irq}, 8'h00);
    bus_read(3'd5, got); check("R6 status at reset", got, 8'h60);
    bus_read(3'd3, got); check("R11 setup reset", got, 8'h03);
    bus_read(3'd1, got); check("R11 enable reset", got, 8'h00);
    bus_read(3'd2, got); check("R11 unused offset", got, 8'h00);

    // register map, R11 / R12
    bus_write(3'd1, 8'hFF);
    bus_read(3'd1, got); check("R11 enable upper zero", got, 8'h0F);
    bus_write(3'd3, 8'hA5);
    bus_read(3'd3, got); check("R11 setup rw", got, 8'hA5);
    repeat (5) @(negedge clk);
    check("R12 rdata held", bus_rdata, 8'hA5);
    bus_write(3'd5, 8'hFF);
    bus_read(3'd5, got); check("R11 status write ignored", got, 8'h60);
    bus_write(3'd1, 8'h01);
    bus_write(3'd3, 8'h03);

    // R1: full byte sweep, 8 bits no parity
    for (int v = 0; v < 256; v++) run_char(8'(v), 2'b11, 0, 1'b0, "R1");

    // R1/R2/R3: length x parity mode matrix
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 5; m++) begin
        for (int k = 0; k < 2; k++) begin
          logic [7:0] dv;
          dv = (k == 0) ? 8'hA7 : 8'h5C;
          run_char(dv, 2'(s), m, 1'b0, (m >= 3) ? "R3" : (m > 0 ? "R2" : "R1"));
          if (m > 0)
            run_char(dv, 2'(s), m, 1'b1, (m >= 3) ? "R3 bad" : "R2 bad");
        end
      end
    end

    // R4: two stop bits, clean then second stop low
    bus_write(3'd3, 8'h06);
    send_frame(8'h2A, 7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    bus_read(3'd5, got); check("R4 two stops clean", got, 8'h61);
    bus_read(3'd0, got); check("R4 data", got, 8'h2A);
    send_frame(8'h56, 7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    repeat (BIT) @(negedge clk);
    bus_read(3'd5, got); check("R4 second stop low", got, 8'h71);
    bus_read(3'd5, got); check("R7 framing cleared", got, 8'h61);
    bus_read(3'd0, got); check("R4 data kept", got, 8'h56);
    bus_read(3'd5, got); check("R4 no phantom char", got, 8'h60);

    // R4: single stop low
    bus_write(3'd3, 8'h03);
    send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (BIT) @(negedge clk);
    bus_read(3'd5, got); check("R4 framing error", got, 8'h71);
    bus_read(3'd0, got); check("R4 framing data", got, 8'hC3);
    bus_read(3'd5, got); check("R4 framing no phantom", got, 8'h60);

    // R10: overrun
    send_frame(8'h11, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    send_frame(8'h22, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    bus_read(3'd5, got); check("R10 overrun", got, 8'h63);
    bus_read(3'd0, got); check("R10 newer data", got, 8'h22);
    bus_read(3'd5, got); check("R10 after reads", got, 8'h60);

    // R9: interrupt disabled
    bus_write(3'd1, 8'h00);
    send_frame(8'h77, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R9 irq masked", {7'd0, irq}, 8'h00);
    bus_read(3'd5, got); check("R9 ready still set", got, 8'h61);
    bus_read(3'd0, got); check("R9 data", got, 8'h77);
    bus_write(3'd1, 8'h01);

    // R5: short glitch ignored, then a real character
    @(negedge clk);
    ser_in = 1'b0;
    repeat (BIT / 4) @(negedge clk);
    ser_in = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    check("R5 no irq on glitch", {7'd0, irq}, 8'h00);
    bus_read(3'd5, got); check("R5 status after glitch", got, 8'h60);
    send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    bus_read(3'd0, got); check("R5 char after glitch", got, 8'h3C);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule